// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block computes one 32-bit arithmetic result per cycle from two operands and an operation code. The result path is purely combinational: signed and unsigned add and subtract that clamp at the range limits instead of wrapping, a doubling that clamps, an add that wraps but still reports overflow, and clamping of a value to a chosen bit width. Width clamping works either on the whole word or on the two 16-bit halves at once.

Every operation that clamps, or that overflows in the case of the wrapping add, raises a saturation event. A single registered sticky flag collects these events. Once set, the flag stays set until a clear strobe or reset. Software-visible condition flags and instruction decode live elsewhere. The datapath around this block selects the operation and reads the result in the same cycle.

Top module: `sat_alu`

## Requirements
- R1: Code 0x0 (signed add) and code 0x1 (signed subtract) detect overflow from the operand and result signs. On overflow the result is 0x7FFFFFFF when a is non-negative and 0x80000000 when a is negative, and a saturation event is raised. Without overflow the exact result is returned.
- R2: Code 0x2 returns the wrapped sum a+b and raises a saturation event exactly when the signed add overflows.
- R3: Code 0x3 doubles a. A signed a of 0x40000000 or more gives 0x7FFFFFFF, and a signed a of 0xC0000000 or less gives 0x80000000; both raise an event. Any other a gives 2*a with no event.
- R4: Code 0x4 (unsigned add) returns 0xFFFFFFFF on carry-out. Code 0x5 (unsigned subtract) returns 0 on borrow. Both raise an event when they clamp.
- R5: Code 0x6 clamps signed a to shift s (input sh_i). If a>>>s is above 0 the result is (1<<s)-1, and if it is below -1 the result is ~((1<<s)-1); both raise an event. Otherwise a passes unchanged.
- R6: Code 0x7 clamps a as a signed value to the unsigned range 0..(1<<s)-1. A negative a gives 0, and a above the limit gives the limit; both raise an event.
- R7: Codes 0x8 (signed) and 0x9 (unsigned) apply the R5 and R6 clamps separately to the sign-extended upper half (bits 31:16) and lower half (bits 15:0) of a. Each clamped half is packed back into its own position, and an event is raised if either half clamps.
- R8: The sticky flag sat_o goes high at the clock edge after a saturation event and stays high through any number of later operations that do not saturate.
- R9: A high clr_i clears the flag at the next edge. If a saturation event occurs in the same cycle as the clear, the flag ends up set.
- R10: Codes 0xA to 0xF return zero and never change the flag.
- R11: Reset (rst_ni low, asynchronous) clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| sh_i | input | 5 | Saturation width shift s for the clamp codes |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (add/subtract codes only) |
| clr_i | input | 1 | Sticky flag clear strobe |
| res_o | output | 32 | Combinational result |
| sat_o | output | 1 | Registered sticky saturation flag |

## Verification
The bench builds the unit with the default 32-bit data width. This places the sign boundaries at exactly 0x7FFFFFFF, 0x80000000, 0x40000000 and 0xC0000000, and the halfword split at bit 16, so the vector table can hit each boundary one value inside and one value outside. The shift input reaches 0, 7, 8 and 15. These include the degenerate zero-width mask and a halfword clamp that can never fire. Directed sequences then test the flag's memory: holding after saturation, clearing, clear and set in the same cycle, and asynchronous reset while set.

// File: rtl/sat_pkg.sv
package sat_pkg;

    // Operation codes carried on op_i; codes above OP_UCLMP2 are unused.
    typedef enum logic [3:0] {
        OP_QADD   = 4'h0,
        OP_QSUB   = 4'h1,
        OP_ADDQ   = 4'h2,
        OP_QDBL   = 4'h3,
        OP_UQADD  = 4'h4,
        OP_UQSUB  = 4'h5,
        OP_SCLMP  = 4'h6,
        OP_UCLMP  = 4'h7,
        OP_SCLMP2 = 4'h8,
        OP_UCLMP2 = 4'h9
    } sat_op_e;

    typedef struct packed {
        logic sticky;
    } sat_state_t;

endpackage

// File: rtl/sat_addsub.sv
// Shared adder/subtractor producing wrapped, signed-clamped and
// unsigned-clamped results plus their overflow indications.
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] s_res_o,
    output logic         s_ovf_o,
    output logic [W-1:0] u_res_o,
    output logic         u_ovf_o
);
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   wide;
    logic [W-1:0] raw;
    logic         res_flip;
    logic         ops_differ;

    always_comb begin
        if (sub_i) begin
            wide = {1'b0, a_i} - {1'b0, b_i};
        end else begin
            wide = {1'b0, a_i} + {1'b0, b_i};
        end
        raw        = wide[W-1:0];
        res_flip   = raw[W-1] ^ a_i[W-1];
        ops_differ = a_i[W-1] ^ b_i[W-1];
        // Signed overflow: result sign moved away from a, with operand
        // signs equal for add and unequal for subtract.
        s_ovf_o = res_flip & (sub_i ? ops_differ : ~ops_differ);
        s_res_o = s_ovf_o ? (a_i[W-1] ? S_MIN : S_MAX) : raw;
        // Unsigned: bit W is carry-out on add and borrow on subtract.
        u_ovf_o = wide[W];
        if (u_ovf_o) begin
            u_res_o = sub_i ? '0 : '1;
        end else begin
            u_res_o = raw;
        end
        raw_o = raw;
    end
endmodule

// File: rtl/sat_double.sv
// Saturating doubling of a signed operand.
module sat_double #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam logic [W-1:0] S_MAX  = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] QTR_HI = {2'b01, {(W-2){1'b0}}};
    localparam logic [W-1:0] QTR_LO = {2'b11, {(W-2){1'b0}}};

    logic hi_clip;
    logic lo_clip;

    always_comb begin
        hi_clip = $signed(a_i) >= $signed(QTR_HI);
        lo_clip = $signed(a_i) <= $signed(QTR_LO);
        sat_o   = hi_clip | lo_clip;
        if (hi_clip) begin
            res_o = S_MAX;
        end else if (lo_clip) begin
            res_o = S_MIN;
        end else begin
            res_o = {a_i[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sat_clamp.sv
// Clamp a signed value to a range set by a shift amount, either to the
// signed range [-(1<<s), (1<<s)-1] or to the unsigned range [0, (1<<s)-1].
// A shift at or beyond VAL_W leaves every value in range.
module sat_clamp #(
    parameter int VAL_W = 32,
    parameter int SH_W  = 5
) (
    input  logic [VAL_W-1:0] val_i,
    input  logic [SH_W-1:0]  sh_i,
    input  logic             uns_i,
    output logic [VAL_W-1:0] res_o,
    output logic             sat_o
);
    localparam logic [VAL_W-1:0] ONE = {{(VAL_W-1){1'b0}}, 1'b1};

    logic [VAL_W-1:0]        mask;
    logic signed [VAL_W-1:0] top;
    logic                    s_pos;
    logic                    s_neg;
    logic                    u_neg;
    logic                    u_over;

    always_comb begin
        mask   = (ONE << sh_i) - ONE;
        top    = $signed(val_i) >>> sh_i;
        s_pos  = ~top[VAL_W-1] & (top != '0);
        s_neg  = top[VAL_W-1] & (top != '1);
        u_neg  = val_i[VAL_W-1];
        u_over = ~val_i[VAL_W-1] & ((val_i & ~mask) != '0);
        res_o  = val_i;
        sat_o  = 1'b0;
        if (uns_i) begin
            if (u_neg) begin
                res_o = '0;
                sat_o = 1'b1;
            end else if (u_over) begin
                res_o = mask;
                sat_o = 1'b1;
            end
        end else begin
            if (s_pos) begin
                res_o = mask;
                sat_o = 1'b1;
            end else if (s_neg) begin
                res_o = ~mask;
                sat_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W = $clog2(DATA_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [3:0]        op_i,
    input  logic [SH_W-1:0]   sh_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] res_o,
    output logic              sat_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int NHALF  = 2;
    localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    // Add / subtract
    logic              as_sub;
    logic [DATA_W-1:0] as_raw;
    logic [DATA_W-1:0] as_sres;
    logic              as_sovf;
    logic [DATA_W-1:0] as_ures;
    logic              as_uovf;

    assign as_sub = (op_i == OP_QSUB) || (op_i == OP_UQSUB);

    sat_addsub #(.W(DATA_W)) u_addsub (
        .a_i     (a_i),
        .b_i     (b_i),
        .sub_i   (as_sub),
        .raw_o   (as_raw),
        .s_res_o (as_sres),
        .s_ovf_o (as_sovf),
        .u_res_o (as_ures),
        .u_ovf_o (as_uovf)
    );

    // Doubling
    logic [DATA_W-1:0] dbl_res;
    logic              dbl_sat;

    sat_double #(.W(DATA_W)) u_double (
        .a_i   (a_i),
        .res_o (dbl_res),
        .sat_o (dbl_sat)
    );

    // Whole-word clamp
    logic [DATA_W-1:0] wc_res;
    logic              wc_sat;

    sat_clamp #(.VAL_W(DATA_W), .SH_W(SH_W)) u_word_clamp (
        .val_i (a_i),
        .sh_i  (sh_i),
        .uns_i (op_i == OP_UCLMP),
        .res_o (wc_res),
        .sat_o (wc_sat)
    );

    // Per-half clamps
    logic [DATA_W-1:0] hc_res;
    logic [NHALF-1:0]  hc_sat;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        sat_clamp #(.VAL_W(HALF_W), .SH_W(SH_W)) u_half_clamp (
            .val_i (a_i[h*HALF_W +: HALF_W]),
            .sh_i  (sh_i),
            .uns_i (op_i == OP_UCLMP2),
            .res_o (hc_res[h*HALF_W +: HALF_W]),
            .sat_o (hc_sat[h])
        );
    end

    // Result select and sticky flag next state
    sat_state_t state_d;
    sat_state_t state_q;
    logic       sat_event;

    always_comb begin
        res_o     = '0;
        sat_event = 1'b0;
        case (op_i)
            OP_QADD, OP_QSUB: begin
                res_o     = as_sres;
                sat_event = as_sovf;
            end
            OP_ADDQ: begin
                res_o     = as_raw;
                sat_event = as_sovf;
            end
            OP_QDBL: begin
                res_o     = dbl_res;
                sat_event = dbl_sat;
            end
            OP_UQADD, OP_UQSUB: begin
                res_o     = as_ures;
                sat_event = as_uovf;
            end
            OP_SCLMP, OP_UCLMP: begin
                res_o     = wc_res;
                sat_event = wc_sat;
            end
            OP_SCLMP2, OP_UCLMP2: begin
                res_o     = hc_res;
                sat_event = |hc_sat;
            end
            default: begin
                res_o     = '0;
                sat_event = 1'b0;
            end
        endcase
        state_d.sticky = (clr_i ? 1'b0 : state_q.sticky) | sat_event;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sat_o = state_q.sticky;

    // R8: a saturation event is visible on the flag one edge later
    a_r8_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sat_event |=> sat_o);

    // R8: without a clear the flag never falls
    a_r8_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sat_o && !clr_i) |=> sat_o);

    // R9: a clear with no competing event empties the flag
    a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !sat_event) |=> !sat_o);

    // R10: unused codes give zero and leave the flag as it was
    a_r10_unused_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i > OP_UCLMP2 && !clr_i) |-> (res_o == '0) ##1 ($stable(sat_o)));

    // R1: a signed overflow yields one of the two range limits
    a_r1_signed_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((op_i == OP_QADD || op_i == OP_QSUB) && as_sovf)
            |-> (res_o == S_MAX || res_o == S_MIN));

    // R4: unsigned add clamp gives all ones
    a_r4_uadd_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_UQADD && as_uovf) |-> (res_o == '1));

endmodule

// File: tb/sat_alu_test.sv
`timescale 1ns/1ps
module sat_alu_test;

    logic        clk;
    logic        rst_n;
    logic [3:0]  op;
    logic [4:0]  sh;
    logic [31:0] a;
    logic [31:0] b;
    logic        clr;
    logic [31:0] res;
    logic        sat;

    int checks = 0;
    int errors = 0;

    sat_alu uut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .op_i   (op),
        .sh_i   (sh),
        .a_i    (a),
        .b_i    (b),
        .clr_i  (clr),
        .res_o  (res),
        .sat_o  (sat)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [3:0]  op;
        logic [4:0]  sh;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        logic        f;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{4'h0, 5'd0,  32'h00000005, 32'h00000003, 32'h00000008, 1'b0},
        '{4'h0, 5'd0,  32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1},
        '{4'h0, 5'd0,  32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1},
        '{4'h1, 5'd0,  32'h80000000, 32'h00000001, 32'h80000000, 1'b1},
        '{4'h1, 5'd0,  32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1},
        '{4'h1, 5'd0,  32'h0000000A, 32'h00000003, 32'h00000007, 1'b0},
        '{4'h2, 5'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1},
        '{4'h2, 5'd0,  32'h00000002, 32'h00000003, 32'h00000005, 1'b0},
        '{4'h3, 5'd0,  32'h3FFFFFFF, 32'h00000000, 32'h7FFFFFFE, 1'b0},
        '{4'h3, 5'd0,  32'h40000000, 32'h00000000, 32'h7FFFFFFF, 1'b1},
        '{4'h3, 5'd0,  32'hC0000000, 32'h00000000, 32'h80000000, 1'b1},
        '{4'h3, 5'd0,  32'hC0000001, 32'h00000000, 32'h80000002, 1'b0},
        '{4'h4, 5'd0,  32'hFFFFFFF0, 32'h00000020, 32'hFFFFFFFF, 1'b1},
        '{4'h4, 5'd0,  32'h00000001, 32'h00000002, 32'h00000003, 1'b0},
        '{4'h5, 5'd0,  32'h00000003, 32'h00000005, 32'h00000000, 1'b1},
        '{4'h5, 5'd0,  32'h00000005, 32'h00000003, 32'h00000002, 1'b0},
        '{4'h6, 5'd7,  32'h00000100, 32'h0000FFFF, 32'h0000007F, 1'b1},
        '{4'h6, 5'd7,  32'hFFFFFF00, 32'h00000000, 32'hFFFFFF80, 1'b1},
        '{4'h6, 5'd7,  32'h0000007F, 32'h00000000, 32'h0000007F, 1'b0},
        '{4'h6, 5'd7,  32'hFFFFFF80, 32'h00000000, 32'hFFFFFF80, 1'b0},
        '{4'h6, 5'd0,  32'h00000005, 32'h00000000, 32'h00000000, 1'b1},
        '{4'h7, 5'd8,  32'h00000100, 32'h00000000, 32'h000000FF, 1'b1},
        '{4'h7, 5'd8,  32'hFFFFFFFF, 32'h00000000, 32'h00000000, 1'b1},
        '{4'h7, 5'd8,  32'h000000FF, 32'h00000000, 32'h000000FF, 1'b0},
        '{4'h8, 5'd7,  32'h0100FF00, 32'h00000000, 32'h007FFF80, 1'b1},
        '{4'h8, 5'd15, 32'h12348000, 32'h00000000, 32'h12348000, 1'b0},
        '{4'h9, 5'd8,  32'h80000050, 32'h00000000, 32'h00000050, 1'b1},
        '{4'h9, 5'd15, 32'h7FFF0001, 32'h00000000, 32'h7FFF0001, 1'b0},
        '{4'hA, 5'd0,  32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b0},
        '{4'hF, 5'd3,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0}
    };

    function automatic string req_of(input logic [3:0] code);
        case (code)
            4'h0, 4'h1: return "R1";
            4'h2:       return "R2";
            4'h3:       return "R3";
            4'h4, 4'h5: return "R4";
            4'h6:       return "R5";
            4'h7:       return "R6";
            4'h8, 4'h9: return "R7";
            default:    return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_clear();
        @(negedge clk);
        op  = 4'hF;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        op    = 4'hF;
        sh    = '0;
        a     = '0;
        b     = '0;
        clr   = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 flag in reset", {31'd0, sat}, 32'd0);
        rst_n = 1'b1;

        // Table walk: each vector starts from a cleared flag
        for (int i = 0; i < NV; i++) begin
            idle_clear();
            op = VEC[i].op;
            sh = VEC[i].sh;
            a  = VEC[i].a;
            b  = VEC[i].b;
            #1;
            check(req_of(VEC[i].op), res, VEC[i].r);
            @(negedge clk);
            op = 4'hF;
            check({req_of(VEC[i].op), " flag"}, {31'd0, sat}, {31'd0, VEC[i].f});
        end

        // R8: flag survives later non-saturating work
        idle_clear();
        op = 4'h0; a = 32'h7FFFFFFF; b = 32'h1;
        @(negedge clk);
        a = 32'h1; b = 32'h1;
        repeat (3) @(negedge clk);
        check("R8 sticky hold", {31'd0, sat}, 32'd1);

        // R10: unused code leaves a set flag set and returns zero
        op = 4'hC; a = 32'h7FFFFFFF; b = 32'h7FFFFFFF;
        #1;
        check("R10 unused result", res, 32'd0);
        @(negedge clk);
        check("R10 flag untouched", {31'd0, sat}, 32'd1);

        // R9: clear alone empties the flag
        op = 4'hF; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R9 clear", {31'd0, sat}, 32'd0);

        // R9: clear together with an event leaves the flag set
        op = 4'h4; a = 32'hFFFFFFFF; b = 32'h1; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; op = 4'hF;
        check("R9 clear with event", {31'd0, sat}, 32'd1);

        // R9: clear with a non-saturating op empties it again
        op = 4'h4; a = 32'h1; b = 32'h1; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; op = 4'hF;
        check("R9 clear with plain op", {31'd0, sat}, 32'd0);

        // R11: asynchronous reset while set
        op = 4'h3; a = 32'h40000000;
        @(negedge clk);
        op = 4'hF;
        check("R11 setup flag", {31'd0, sat}, 32'd1);
        #1;
        rst_n = 1'b0;
        #1;
        check("R11 async reset", {31'd0, sat}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after release", {31'd0, sat}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule